// File: doc/BRIEF.md
# Page-Translating DMA Channel

This block is one DMA channel that carries bytes between a peripheral byte stream and system memory. Software programs the channel with a start address and a byte count. These addresses are logical. Each logical address is mapped to a physical one through a scatter-gather table kept in memory. The table has one 8-byte slot per 4 KB page, and the channel uses only the first 32-bit word of each slot. The channel reads that word over its memory port when a transfer starts, and again each time the logical address enters a new page. It then joins the page number taken from the word to the offset inside the page.

The direction bit is defined from the device's side. When set, data flows toward the device, so memory is read and bytes leave on the outbound stream. When clear, bytes arrive on the inbound stream and are written to memory. A request to start a transfer must name a direction that agrees with this bit, and the run bit must be set. Otherwise the request is refused and nothing moves. A transfer ends when the logical address reaches start plus count, or, when writing to memory, after the byte that the peripheral flags as its last. The count register then reads zero and a one-cycle done pulse is raised.

Top module: `pgxl_dma`

## Requirements
- R1: Register offsets on `regAddr` are: start address 0x18, table limit 0x28, byte count 0x10, table base 0x20, mode 0x00, enable 0x08. Each reads back the 32-bit value last written to it. All of them read zero after reset, and any other offset reads zero.
- R2: Enable bit 0 is the run bit. A start request made while it is clear raises `rejectP` for one cycle, makes no memory access and leaves the count register unchanged.
- R3: Enable bit 1 is the write bit: 1 means toward the device (memory read), 0 means toward memory. A start request whose `xferToMem` equals the write bit is refused with `rejectP`, and no byte moves.
- R4: A table entry is fetched with `memWord`=1 at address table base + (logical address >> 12) * 8. The returned 32-bit word is little-endian, with the byte at the lowest address in bits 7:0.
- R5: The physical byte address is entry bits 31:12 followed by logical address bits 11:0. The low 12 bits of the entry are ignored.
- R6: Toward the device, bytes are read from memory in logical order (data in `memRdata[7:0]`) and sent on `outData`. Toward memory, bytes taken from `inData` are written in logical order using `memWdata`.
- R7: A transfer moves exactly count bytes, from logical address start up to but not including start + count. A count of zero gives done with no memory access.
- R8: Toward memory, a byte accepted with `inLast`=1 is the final byte. No further byte is taken from the stream and no further byte is written.
- R9: Every accepted transfer ends with a one-cycle `doneP`, after which the count register reads zero.
- R10: A table entry is fetched once at the start of a non-empty transfer and again only when the logical address crosses into a new 4 KB page.
- R11: `memReq` stays high, with `memAddr` and `memWe` stable, until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| xferStart | input | 1 | Request to start a transfer |
| xferToMem | input | 1 | Requested direction, 1 = toward memory |
| doneP | output | 1 | Transfer finished pulse |
| rejectP | output | 1 | Start request refused pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a byte write |
| memWord | output | 1 | Memory access is a 32-bit table read |
| memAddr | output | 32 | Memory physical address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 32 | Read data (word, or byte in bits 7:0) |
| memAck | input | 1 | Memory access complete |
| inValid | input | 1 | Inbound stream byte valid |
| inData | input | 8 | Inbound stream byte |
| inLast | input | 1 | Inbound byte is the final one |
| inReady | output | 1 | Channel takes an inbound byte |
| outValid | output | 1 | Outbound stream byte valid |
| outData | output | 8 | Outbound stream byte |
| outReady | input | 1 | Peripheral takes the outbound byte |

## Verification
The bench runs directed transfers that start two bytes below a page boundary, sit on the last byte of a page, or carry a zero count. These separate a channel that refetches the entry correctly at a crossing from one that fetches too often or too seldom. Random transfers then vary the start, the count and the direction, along with stalls on both streams and an early `inLast` at random positions. The moved bytes are compared with a bench page map whose table entries carry junk low bits, so a wrong page join, a misread byte order or an overrun past the count shows up as corrupted data or an extra memory access. Refused requests, caused either by a clear run bit or by a direction mismatch, are checked through the memory access counters and the unchanged count register.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFF_MODE  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_ENA   = 6'h08;
  localparam logic [REG_AW-1:0] OFF_CNT   = 6'h10;
  localparam logic [REG_AW-1:0] OFF_START = 6'h18;
  localparam logic [REG_AW-1:0] OFF_BASE  = 6'h20;
  localparam logic [REG_AW-1:0] OFF_LIMIT = 6'h28;

  localparam int EN_RUN_BIT = 0;
  localparam int EN_WR_BIT  = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_REJ, S_FIRST, S_FETCH, S_RDMEM,
    S_PUSH, S_PULL, S_WRMEM, S_STEP, S_FIN
  } pgxl_state_e;

  typedef struct packed {
    logic ldStart;
    logic ldEntry;
    logic capMem;
    logic capIn;
    logic incAddr;
    logic clrCnt;
    logic useTbl;
  } pgxl_strobe_t;
endpackage

// File: rtl/pgxl_dpath.sv
module pgxl_dpath
  import pgxl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  pgxl_strobe_t         stb,
  input  logic [ADDR_W-1:0]    memRdata,
  input  logic [BYTE_W-1:0]    inData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BYTE_W-1:0]    byteOut,
  output logic                 runBit,
  output logic                 wrBit,
  output logic                 atEnd,
  output logic                 pageEdge
);
  localparam int PN_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] modeReg, enaReg, cntReg, startReg, baseReg, limitReg;
  logic [ADDR_W-1:0] logAddr, endAddr;
  logic [PN_W-1:0]   pageReg;
  logic [BYTE_W-1:0] dataBuf;
  logic [ADDR_W-1:0] slotOffset;
  logic              unusedBits;

  assign unusedBits = ^memRdata[PAGE_BITS-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      enaReg   <= '0;
      cntReg   <= '0;
      startReg <= '0;
      baseReg  <= '0;
      limitReg <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          OFF_MODE:  modeReg  <= regWdata;
          OFF_ENA:   enaReg   <= regWdata;
          OFF_START: startReg <= regWdata;
          OFF_BASE:  baseReg  <= regWdata;
          OFF_LIMIT: limitReg <= regWdata;
          default: ;
        endcase
      end
      if (stb.clrCnt)
        cntReg <= '0;
      else if (regWe && regAddr == OFF_CNT)
        cntReg <= regWdata;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_MODE:  regRdata = modeReg;
      OFF_ENA:   regRdata = enaReg;
      OFF_CNT:   regRdata = cntReg;
      OFF_START: regRdata = startReg;
      OFF_BASE:  regRdata = baseReg;
      OFF_LIMIT: regRdata = limitReg;
      default:   regRdata = '0;
    endcase
  end

  // Working state for the running transfer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      logAddr <= '0;
      endAddr <= '0;
      pageReg <= '0;
      dataBuf <= '0;
    end else begin
      if (stb.ldStart) begin
        logAddr <= startReg;
        endAddr <= startReg + cntReg;
      end else if (stb.incAddr) begin
        logAddr <= logAddr + 1'b1;
      end
      if (stb.ldEntry) pageReg <= memRdata[ADDR_W-1:PAGE_BITS];
      if (stb.capMem)
        dataBuf <= memRdata[BYTE_W-1:0];
      else if (stb.capIn)
        dataBuf <= inData;
    end
  end

  assign slotOffset = {{PAGE_BITS{1'b0}}, logAddr[ADDR_W-1:PAGE_BITS]} << ENTRY_SHIFT;
  assign memAddr    = stb.useTbl ? (baseReg + slotOffset)
                                 : {pageReg, logAddr[PAGE_BITS-1:0]};
  assign byteOut    = dataBuf;
  assign runBit     = enaReg[EN_RUN_BIT];
  assign wrBit      = enaReg[EN_WR_BIT];
  assign atEnd      = (logAddr == endAddr);
  assign pageEdge   = (logAddr[PAGE_BITS-1:0] == '0);
endmodule

// File: rtl/pgxl_ctrl.sv
module pgxl_ctrl
  import pgxl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         xferStart,
  input  logic         xferToMem,
  input  logic         runBit,
  input  logic         wrBit,
  input  logic         atEnd,
  input  logic         pageEdge,
  input  logic         memAck,
  input  logic         inValid,
  input  logic         inLast,
  input  logic         outReady,
  output pgxl_strobe_t stb,
  output logic         memReq,
  output logic         memWe,
  output logic         memWord,
  output logic         inReady,
  output logic         outValid,
  output logic         doneP,
  output logic         rejectP
);
  pgxl_state_e state, nxt;
  logic toMemQ, lastQ;

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_IDLE: if (xferStart) begin
        if (runBit && (xferToMem != wrBit)) begin
          stb.ldStart = 1'b1;
          nxt = S_FIRST;
        end else begin
          nxt = S_REJ;
        end
      end
      S_REJ:   nxt = S_IDLE;
      S_FIRST: nxt = atEnd ? S_FIN : S_FETCH;
      S_FETCH: begin
        stb.useTbl = 1'b1;
        if (memAck) begin
          stb.ldEntry = 1'b1;
          nxt = toMemQ ? S_PULL : S_RDMEM;
        end
      end
      S_RDMEM: if (memAck) begin
        stb.capMem = 1'b1;
        nxt = S_PUSH;
      end
      S_PUSH: if (outReady) begin
        stb.incAddr = 1'b1;
        nxt = S_STEP;
      end
      S_PULL: if (inValid) begin
        stb.capIn = 1'b1;
        nxt = S_WRMEM;
      end
      S_WRMEM: if (memAck) begin
        stb.incAddr = 1'b1;
        nxt = S_STEP;
      end
      S_STEP: begin
        if (atEnd || lastQ)  nxt = S_FIN;
        else if (pageEdge)   nxt = S_FETCH;
        else                 nxt = toMemQ ? S_PULL : S_RDMEM;
      end
      S_FIN: begin
        stb.clrCnt = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      toMemQ <= 1'b0;
      lastQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.ldStart) begin
        toMemQ <= xferToMem;
        lastQ  <= 1'b0;
      end else if (stb.capIn) begin
        lastQ <= inLast;
      end
    end
  end

  assign memReq   = (state == S_FETCH) || (state == S_RDMEM) || (state == S_WRMEM);
  assign memWe    = (state == S_WRMEM);
  assign memWord  = (state == S_FETCH);
  assign inReady  = (state == S_PULL);
  assign outValid = (state == S_PUSH);
  assign doneP    = (state == S_FIN);
  assign rejectP  = (state == S_REJ);

  AST_FETCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH && $past(state) == S_STEP) |-> pageEdge); // R10
  AST_QUIET_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneP, rejectP, memReq, inReady, outValid})); // R3
endmodule

// File: rtl/pgxl_dma.sv
module pgxl_dma
  import pgxl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              xferStart,
  input  logic              xferToMem,
  output logic              doneP,
  output logic              rejectP,
  output logic              memReq,
  output logic              memWe,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  input  logic              outReady
);
  pgxl_strobe_t      stb;
  logic              runBit, wrBit, atEnd, pageEdge;
  logic [BYTE_W-1:0] byteOut;

  pgxl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferToMem(xferToMem),
    .runBit(runBit), .wrBit(wrBit), .atEnd(atEnd), .pageEdge(pageEdge),
    .memAck(memAck), .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .stb(stb), .memReq(memReq), .memWe(memWe), .memWord(memWord),
    .inReady(inReady), .outValid(outValid), .doneP(doneP), .rejectP(rejectP)
  );

  pgxl_dpath #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .memRdata(memRdata),
    .inData(inData), .memAddr(memAddr), .byteOut(byteOut), .runBit(runBit),
    .wrBit(wrBit), .atEnd(atEnd), .pageEdge(pageEdge)
  );

  assign memWdata = byteOut;
  assign outData  = byteOut;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R11
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWord) |-> !atEnd); // R7
endmodule

// File: tb/sim_pgxl_dma.sv
module sim_pgxl_dma;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xferStart = 1'b0, xferToMem = 1'b0;
  logic        doneP, rejectP, memReq, memWe, memWord;
  logic [31:0] memAddr, memRdata = '0;
  logic [7:0]  memWdata, inData, outData;
  logic        memAck = 1'b0;
  logic        inValid, inLast, inReady, outValid;
  logic        outReady = 1'b0, stallIn = 1'b0;

  pgxl_dma u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .xferStart(xferStart), .xferToMem(xferToMem), .doneP(doneP),
    .rejectP(rejectP), .memReq(memReq), .memWe(memWe), .memWord(memWord),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  localparam logic [5:0] A_MODE = 6'h00, A_ENA = 6'h08, A_CNT = 6'h10,
                         A_START = 6'h18, A_BASE = 6'h20, A_LIMIT = 6'h28;
  localparam int TB_BASE = 32'h0100;

  logic [7:0] mem [0:16383];
  logic [7:0] srcBuf [0:16383];
  logic [7:0] snk [0:16383];
  int pmap [0:7];
  int srcIdx = 0, srcLen = 0, lastIdx = 0, snkN = 0;
  int fetchCnt = 0, byteCnt = 0, lastFetch = 0;
  bit lastEn = 1'b0;
  int nChk = 0, nFail = 0;

  // Memory model: one-cycle acknowledge
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWord) begin
        memRdata  <= {mem[memAddr[13:0] + 14'd3], mem[memAddr[13:0] + 14'd2],
                      mem[memAddr[13:0] + 14'd1], mem[memAddr[13:0]]};
        fetchCnt  <= fetchCnt + 1;
        lastFetch <= memAddr;
      end else begin
        if (memWe) mem[memAddr[13:0]] <= memWdata;
        else memRdata <= {24'hA5C35A, mem[memAddr[13:0]]};
        byteCnt <= byteCnt + 1;
      end
    end
  end

  assign inValid = (srcIdx < srcLen) && !stallIn;
  assign inData  = srcBuf[srcIdx[13:0]];
  assign inLast  = lastEn && (srcIdx == lastIdx);

  always @(posedge clk) begin
    stallIn  <= ($urandom_range(0, 3) == 0);
    outReady <= ($urandom_range(0, 3) != 0);
    if (inValid && inReady) srcIdx <= srcIdx + 1;
    if (outValid && outReady) begin
      snk[snkN[13:0]] <= outData;
      snkN <= snkN + 1;
    end
  end

  function automatic int xl(input int la);
    return (pmap[(la >> 12) & 7] << 12) | (la & 32'hFFF);
  endfunction

  function automatic int pagesOf(input int st, input int n);
    if (n == 0) return 0;
    return ((st + n - 1) >> 12) - (st >> 12) + 1;
  endfunction

  task automatic chkEq(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic startXfer(input bit tm, output bit gotD, output bit gotR);
    @(negedge clk);
    xferStart = 1'b1; xferToMem = tm;
    @(negedge clk);
    xferStart = 1'b0;
    gotD = 1'b0; gotR = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (doneP || rejectP) break;
      @(negedge clk);
    end
    gotD = doneP; gotR = rejectP;
  endtask

  task automatic xfer(input int st, input int cnt, input bit toMem, input int lastAt,
                      input string tag);
    int sBase, kBase, n, f0, b0, bad;
    logic [7:0] pre;
    bit gotD, gotR;
    logic [31:0] v;
    sBase = srcIdx; kBase = snkN;
    for (int i = 0; i < cnt + 4; i++) srcBuf[(sBase + i) & 16383] = 8'($urandom);
    lastEn  = toMem && (lastAt >= 0);
    lastIdx = sBase + lastAt;
    srcLen  = toMem ? sBase + cnt + 4 : sBase;
    n = (toMem && lastAt >= 0 && lastAt < cnt) ? lastAt + 1 : cnt;
    pre = mem[xl(st + n) & 16383];
    regWrite(A_CNT, cnt);
    regWrite(A_START, st);
    regWrite(A_ENA, toMem ? 32'h1 : 32'h3);
    f0 = fetchCnt; b0 = byteCnt;
    startXfer(toMem, gotD, gotR);
    chkEq({"R9 done pulse ", tag}, {gotR, gotD}, 2'b01);
    @(negedge clk);
    regRead(A_CNT, v);
    chkEq({"R9 count cleared ", tag}, v, 0);
    chkEq({"R10 entry fetches ", tag}, fetchCnt - f0, pagesOf(st, n));
    chkEq({"R7 bytes moved ", tag}, byteCnt - b0, n);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (toMem) begin
        if (mem[xl(st + i) & 16383] !== srcBuf[(sBase + i) & 16383]) bad++;
      end else begin
        if (snk[(kBase + i) & 16383] !== mem[xl(st + i) & 16383]) bad++;
      end
    end
    chkEq({"R6 R5 data ", tag}, bad, 0);
    if (toMem) begin
      chkEq({"R8 stream bytes taken ", tag}, srcIdx - sBase, n);
      if (n < cnt) chkEq({"R8 byte past last untouched ", tag}, mem[xl(st + n) & 16383], pre);
    end else begin
      chkEq({"R6 stream bytes sent ", tag}, snkN - kBase, n);
    end
    lastEn = 1'b0;
    srcLen = srcIdx;
  endtask

  initial begin
    #(8 * 190000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit gotD, gotR;
    int f0, b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16384; i++) mem[i] = 8'($urandom);
    for (int p = 0; p < 8; p++) begin
      int e;
      pmap[p] = 1 + ((p * 2 + 1) % 3);
      e = (pmap[p] << 12) | ((p == 0) ? 32'hABC : $urandom_range(0, 4095));
      for (int k = 0; k < 4; k++) mem[TB_BASE + p * 8 + k] = 8'(e >> (8 * k));
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and readback
    regRead(A_MODE, v);  chkEq("R1 mode reset", v, 0);
    regRead(A_ENA, v);   chkEq("R1 enable reset", v, 0);
    regRead(A_CNT, v);   chkEq("R1 count reset", v, 0);
    regRead(A_START, v); chkEq("R1 start reset", v, 0);
    regRead(A_BASE, v);  chkEq("R1 base reset", v, 0);
    regRead(A_LIMIT, v); chkEq("R1 limit reset", v, 0);
    regWrite(A_MODE, 32'h1234_5678);  regRead(A_MODE, v);  chkEq("R1 mode rw", v, 32'h1234_5678);
    regWrite(A_LIMIT, 32'h0000_7FFF); regRead(A_LIMIT, v); chkEq("R1 limit rw", v, 32'h7FFF);
    regWrite(A_BASE, TB_BASE);        regRead(A_BASE, v);  chkEq("R1 base rw", v, TB_BASE);
    regRead(6'h30, v); chkEq("R1 unmapped reads zero", v, 0);

    // R2 run bit clear refuses
    regWrite(A_CNT, 7); regWrite(A_START, 32'h40); regWrite(A_ENA, 32'h2);
    f0 = fetchCnt; b0 = byteCnt;
    startXfer(1'b0, gotD, gotR);
    chkEq("R2 reject when not running", {gotR, gotD}, 2'b10);
    repeat (3) @(negedge clk);
    chkEq("R2 no memory access", (fetchCnt - f0) + (byteCnt - b0), 0);
    regRead(A_CNT, v); chkEq("R2 count kept", v, 7);

    // R3 direction mismatch, both ways
    regWrite(A_ENA, 32'h3);
    startXfer(1'b1, gotD, gotR);
    chkEq("R3 reject toward-memory when write bit set", {gotR, gotD}, 2'b10);
    regWrite(A_ENA, 32'h1);
    startXfer(1'b0, gotD, gotR);
    chkEq("R3 reject toward-device when write bit clear", {gotR, gotD}, 2'b10);
    repeat (3) @(negedge clk);
    chkEq("R3 nothing moved", (fetchCnt - f0) + (byteCnt - b0) + snkN, 0);
    regRead(A_CNT, v); chkEq("R3 count kept", v, 7);

    // Directed corners
    xfer(32'h0FFE, 5, 1'b0, -1, "cross page to device");
    chkEq("R4 entry address at crossing", lastFetch, TB_BASE + 8);
    xfer(32'h0000, 3, 1'b0, -1, "page0 junk entry bits R5");
    chkEq("R4 entry address page0", lastFetch, TB_BASE);
    xfer(32'h1FFF, 1, 1'b1, -1, "last byte of page to memory");
    xfer(32'h2000, 0, 1'b0, -1, "zero count R7");
    xfer(32'h3FF0, 40, 1'b1, 17, "early last R8");
    xfer(32'h4FFC, 8, 1'b1, 3, "last at page end R8");

    // Random transfers
    for (int t = 0; t < 24; t++) begin
      int cnt, st, la;
      bit tm;
      cnt = $urandom_range(1, 300);
      st  = $urandom_range(0, 32'h8000 - cnt - 1);
      tm  = 1'($urandom_range(0, 1));
      la  = (tm && $urandom_range(0, 1)) ? $urandom_range(0, cnt - 1) : -1;
      xfer(st, cnt, tm, la, "random");
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule